// File: doc/BRIEF.md
# Adaptive Supply-Current Controller

This controller finds and then holds the smallest supply-current setting at which a monitored datapath still produces correct results. It drives a binary-weighted code to an external bank of current switches. Each code bit turns on one switch, and switch weight grows with bit position, so the delivered current rises linearly with the code value.

After reset, and whenever a restart is requested, the controller runs a successive-approximation search. It resolves one code bit per trial, starting with the most significant bit. Each trial is judged by a pass/fail error-check input from the datapath. After the trial for the least significant bit, the controller applies the result and confirms it with one more trial. It then reports that it is locked.

From then on it tracks conditions. A flag from a least-significant-bit checker raises the code by one step at once. A timing-slack reading from a time-to-digital converter lowers the code by one step, but only after the slack has stayed generous for a programmable number of consecutive sample windows. After every code change, a settle timer blocks all further decisions until the switch bank and the datapath have settled.

Top module: `cur_scale_ctrl`

## Requirements
- R1: While reset is asserted, `code_o` is 255, `state_o` is 0 (searching) and `fault_o` is 0.
- R2: A search makes 8 trials, from the MSB to the LSB, followed by one confirming trial. Each trial holds its code for `settle_i`+1 cycles and samples `err_i` (1 = wrong result) in the last of those cycles. When `err_i` is low exactly for codes at or above a threshold T ≤ 255, the search ends with `code_o` = T. From the cycle in which a restart is seen, it takes 9·`settle_i`+10 cycles to reach the locked state.
- R3: During a search, `lsb_err_i` and `win_valid_i` have no effect on the search result.
- R4: When a search completes without a fault, `state_o` is 1 (locked). It changes to 2 (tracking) at the first tracking event the controller processes, either an LSB error or a slack window.
- R5: While locked or tracking and not settling, `lsb_err_i` high raises `code_o` by 1 on the next edge. The code saturates at 255.
- R6: While locked or tracking, `code_o` drops by 1 after `win_need_i` consecutive processed windows in which `slack_i` > `slack_thr_i`, saturating at 0. A window with `slack_i` ≤ `slack_thr_i`, or a raise, restarts the count.
- R7: After a code change, the controller ignores `lsb_err_i` and `win_valid_i` for `settle_i` cycles.
- R8: `restart_i` high in any state other than fault starts a new search.
- R9: If the confirming trial at code 255 still sees `err_i` high, `fault_o` is set and `state_o` becomes 3. Both stay set, with `code_o` held at 255, until reset. `restart_i` has no effect while the fault is set.
- R10: While tracking, `code_o` never moves by more than one step per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Start a new search |
| settle_i | input | 8 | Settle time in cycles after a code change |
| err_i | input | 1 | Error-check result, 1 = datapath wrong at current code |
| lsb_err_i | input | 1 | LSB checker error flag |
| win_valid_i | input | 1 | One-cycle strobe marking a slack sample window |
| slack_i | input | 6 | Timing-slack reading from the TDC |
| slack_thr_i | input | 6 | Slack level above which a window counts as generous |
| win_need_i | input | 4 | Consecutive generous windows required before lowering (0 acts as 1) |
| code_o | output | 8 | Current-switch code |
| state_o | output | 2 | 0 searching, 1 locked, 2 tracking, 3 fault |
| fault_o | output | 1 | Sticky search fault |

## Verification
The assertions take for granted that `err_i` depends only on the code already applied. They also assume that `settle_i` and the slack controls do not change while a timed window is open. The bench keeps within this by deriving `err_i` combinationally from `code_o` and a fixed threshold. It changes the settle value only between searches and drives each strobe as a single-cycle pulse set between clock edges. The threshold scenarios are chosen so that the monotonic pass/fail relation the search relies on always holds.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [2:0] {
    P_INIT, P_TRIAL, P_VERIFY, P_LOCK, P_TRACK, P_FAULT
  } phase_e;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_LOCKED = 2'd1,
    ST_TRACK  = 2'd2,
    ST_FAULT  = 2'd3
  } status_e;
endpackage

// File: rtl/cs_settle_timer.sv
module cs_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R7
  settle_countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/cs_sar_core.sv
module cs_sar_core #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         fail_i,
  output logic [W-1:0] next_code_o,
  output logic         last_o
);
  logic [W-1:0]     res_q, res_n, bit_w;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    bit_w  = {{(W-1){1'b0}}, 1'b1} << idx_q;
    res_n  = res_q | (fail_i ? bit_w : '0);
    last_o = (idx_q == '0);
    // next trial: resolved bits plus all ones below the next bit under test
    next_code_o = last_o ? res_n : (res_n | ((bit_w >> 1) - 1'b1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      idx_q <= IDX_W'(W-1);
    end else if (start_i) begin
      res_q <= '0;
      idx_q <= IDX_W'(W-1);
    end else if (step_i) begin
      res_q <= res_n;
      if (!last_o) idx_q <= idx_q - 1'b1;
    end
  end

  // R2
  msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i && !last_o) |=> (idx_q == IDX_W'($past(idx_q) - 1'b1)));
endmodule

// File: rtl/cs_slack_track.sv
module cs_slack_track #(
  parameter int SLACK_W = 6,
  parameter int WIN_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic               sample_i,
  input  logic [SLACK_W-1:0] slack_i,
  input  logic [SLACK_W-1:0] thr_i,
  input  logic [WIN_W-1:0]   win_i,
  output logic               lower_o
);
  logic [WIN_W-1:0] cnt_q;
  logic             above, hit, take;

  always_comb begin
    above   = (slack_i > thr_i);
    hit     = ({1'b0, cnt_q} + 1'b1) >= {1'b0, win_i};
    take    = en_i && sample_i;
    lower_o = take && above && hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (take) begin
      if (!above || hit)        cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cur_scale_ctrl.sv
module cur_scale_ctrl
  import cs_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SETTLE_W = 8,
  parameter int SLACK_W  = 6,
  parameter int WIN_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                err_i,
  input  logic                lsb_err_i,
  input  logic                win_valid_i,
  input  logic [SLACK_W-1:0]  slack_i,
  input  logic [SLACK_W-1:0]  slack_thr_i,
  input  logic [WIN_W-1:0]    win_need_i,
  output logic [CODE_W-1:0]   code_o,
  output logic [1:0]          state_o,
  output logic                fault_o
);
  localparam logic [CODE_W-1:0] CODE_MAX   = '1;
  localparam logic [CODE_W-1:0] CODE_FIRST = {1'b0, {(CODE_W-1){1'b1}}};

  phase_e            st_q, st_d;
  logic [CODE_W-1:0] code_q, code_d, sar_next;
  logic              fault_q, fault_d;
  logic              busy, tmr_load, sar_last, lower;
  logic              trk, ev_up, ev_any;

  assign trk    = (st_q == P_LOCK) || (st_q == P_TRACK);
  assign ev_up  = trk && !busy && lsb_err_i;
  assign ev_any = trk && !busy && (lsb_err_i || win_valid_i);

  cs_settle_timer #(.W(SETTLE_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(settle_i), .busy_o(busy)
  );

  cs_sar_core #(.W(CODE_W)) u_sar (
    .clk_i, .rst_ni,
    .start_i    (st_q == P_INIT),
    .step_i     (st_q == P_TRIAL && !busy),
    .fail_i     (err_i),
    .next_code_o(sar_next),
    .last_o     (sar_last)
  );

  cs_slack_track #(.SLACK_W(SLACK_W), .WIN_W(WIN_W)) u_track (
    .clk_i, .rst_ni,
    .clr_i   (!trk || ev_up),
    .en_i    (trk && !busy && !lsb_err_i),
    .sample_i(win_valid_i),
    .slack_i,
    .thr_i   (slack_thr_i),
    .win_i   (win_need_i),
    .lower_o (lower)
  );

  always_comb begin
    st_d     = st_q;
    code_d   = code_q;
    fault_d  = fault_q;
    tmr_load = 1'b0;
    if (restart_i && st_q != P_FAULT) begin
      st_d = P_INIT;
    end else begin
      unique case (st_q)
        P_INIT: begin
          code_d   = CODE_FIRST;
          tmr_load = 1'b1;
          st_d     = P_TRIAL;
        end
        P_TRIAL: if (!busy) begin
          code_d   = sar_next;
          tmr_load = 1'b1;
          if (sar_last) st_d = P_VERIFY;
        end
        P_VERIFY: if (!busy) begin
          if (err_i && code_q == CODE_MAX) begin
            st_d    = P_FAULT;
            fault_d = 1'b1;
          end else begin
            st_d = P_LOCK;
          end
        end
        P_LOCK, P_TRACK: begin
          if (ev_any) st_d = P_TRACK;
          if (ev_up) begin
            if (code_q != CODE_MAX) begin
              code_d   = code_q + 1'b1;
              tmr_load = 1'b1;
            end
          end else if (lower && code_q != '0) begin
            code_d   = code_q - 1'b1;
            tmr_load = 1'b1;
          end
        end
        default: code_d = CODE_MAX;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= P_INIT;
      code_q  <= CODE_MAX;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      code_q  <= code_d;
      fault_q <= fault_d;
    end
  end

  always_comb begin
    unique case (st_q)
      P_LOCK:  state_o = ST_LOCKED;
      P_TRACK: state_o = ST_TRACK;
      P_FAULT: state_o = ST_FAULT;
      default: state_o = ST_SEARCH;
    endcase
  end

  assign code_o  = code_q;
  assign fault_o = fault_q;

  // R10
  track_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == P_TRACK) |-> (code_q == $past(code_q) ||
                           code_q == CODE_W'($past(code_q) + 1'b1) ||
                           code_q == CODE_W'($past(code_q) - 1'b1)));
  // R7
  settle_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk && busy && !restart_i) |=> $stable(code_q));
  // R5
  lsb_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk && !busy && lsb_err_i && !restart_i && code_q != CODE_MAX)
      |=> (code_q == CODE_W'($past(code_q) + 1'b1)));
  // R9
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);
  // R9
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (code_o == CODE_MAX && state_o == ST_FAULT));
endmodule

// File: tb/tb_cur_scale_ctrl.sv
`timescale 1ns/1ps
module tb_cur_scale_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       restart_i = 1'b0;
  logic [7:0] settle_i = 8'd2;
  logic       err_i;
  logic       lsb_err_i = 1'b0;
  logic       win_valid_i = 1'b0;
  logic [5:0] slack_i = '0;
  logic [5:0] slack_thr_i = 6'd10;
  logic [3:0] win_need_i = 4'd3;
  logic [7:0] code_o;
  logic [1:0] state_o;
  logic       fault_o;
  logic [8:0] thr_t = 9'd37;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  // datapath model: wrong whenever code is below the threshold
  always_comb err_i = ({1'b0, code_o} < thr_t);

  cur_scale_ctrl dut (.*);

  // {threshold, settle}
  localparam logic [16:0] VEC [0:7] = '{
    {9'd0, 8'd0}, {9'd1, 8'd2}, {9'd5, 8'd1}, {9'd127, 8'd3},
    {9'd128, 8'd0}, {9'd200, 8'd5}, {9'd254, 8'd2}, {9'd255, 8'd1}
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_search(input logic [8:0] t, input logic [7:0] s, output int cyc);
    thr_t = t;
    settle_i = s;
    @(negedge clk_i) restart_i = 1'b1;
    @(negedge clk_i) restart_i = 1'b0;
    cyc = 0;
    while (state_o == 2'd0) begin
      @(negedge clk_i);
      cyc++;
    end
  endtask

  task automatic pulse_lsb();
    @(negedge clk_i) lsb_err_i = 1'b1;
    @(negedge clk_i) lsb_err_i = 1'b0;
  endtask

  task automatic pulse_win(input logic [5:0] sl);
    @(negedge clk_i) begin win_valid_i = 1'b1; slack_i = sl; end
    @(negedge clk_i) win_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int cyc;
    idle(3);
    // R1 reset state
    chk(code_o == 8'd255, "R1 reset code", code_o, 255);
    chk(state_o == 2'd0, "R1 reset state", state_o, 0);
    chk(fault_o == 1'b0, "R1 reset fault", fault_o, 0);
    rst_ni = 1'b1;
    while (state_o == 2'd0) @(negedge clk_i);
    chk(code_o == 8'd37, "R2 search after reset", code_o, 37);

    // vector walk over search thresholds and settle times
    for (int i = 0; i < 8; i++) begin
      logic [8:0] t;
      logic [7:0] s;
      {t, s} = VEC[i];
      if (i == 5) begin  // R3: tracking inputs active through the whole search
        lsb_err_i = 1'b1; win_valid_i = 1'b1; slack_i = 6'd63;
      end
      run_search(t, s, cyc);
      lsb_err_i = 1'b0; win_valid_i = 1'b0;
      chk(code_o == t[7:0], (i == 5) ? "R3 search code" : "R2 search code", code_o, t);
      chk(cyc == 9 * s + 10, "R2 search cycles", cyc, 9 * s + 10);
      chk(state_o == 2'd1, "R4 locked", state_o, 1);
    end

    // R5 saturation at 255 (locked at 255)
    pulse_lsb();
    chk(code_o == 8'd255, "R5 raise saturates", code_o, 255);
    chk(state_o == 2'd2, "R4 tracking after event", state_o, 2);

    // R8 restart from tracking
    run_search(9'd100, 8'd3, cyc);
    chk(code_o == 8'd100 && state_o == 2'd1, "R8 restart relock", code_o, 100);
    pulse_lsb();
    chk(code_o == 8'd101, "R5 lsb raise", code_o, 101);
    pulse_lsb();  // timer still running
    chk(code_o == 8'd101, "R7 blocked while settling", code_o, 101);
    idle(5);
    pulse_lsb();
    chk(code_o == 8'd102, "R5 raise after settle", code_o, 102);
    idle(5);

    // R6 lowering after consecutive generous windows
    pulse_win(6'd20);
    pulse_win(6'd20);
    chk(code_o == 8'd102, "R6 not yet lowered", code_o, 102);
    pulse_win(6'd20);
    chk(code_o == 8'd101, "R6 lowered", code_o, 101);
    idle(5);
    pulse_win(6'd20);
    pulse_win(6'd20);
    pulse_win(6'd10);  // equal to threshold: breaks the run
    pulse_win(6'd20);
    pulse_win(6'd20);
    chk(code_o == 8'd101, "R6 run broken", code_o, 101);
    pulse_win(6'd20);
    chk(code_o == 8'd100, "R6 lowered after new run", code_o, 100);

    // R6 saturation at 0
    run_search(9'd0, 8'd1, cyc);
    win_need_i = 4'd1;
    pulse_win(6'd30);
    chk(code_o == 8'd0, "R6 lower saturates", code_o, 0);
    chk(state_o == 2'd2, "R4 tracking on window", state_o, 2);

    // R9 fault when even the top code fails
    run_search(9'd256, 8'd2, cyc);
    chk(state_o == 2'd3, "R9 fault state", state_o, 3);
    chk(fault_o == 1'b1, "R9 fault flag", fault_o, 1);
    chk(code_o == 8'd255, "R9 fault code", code_o, 255);
    chk(cyc == 9 * 2 + 10, "R2 cycles to fault", cyc, 28);
    @(negedge clk_i) restart_i = 1'b1;
    @(negedge clk_i) restart_i = 1'b0;
    idle(3);
    chk(state_o == 2'd3 && fault_o, "R9 restart ignored", state_o, 3);
    chk(code_o == 8'd255, "R9 code held", code_o, 255);

    // R1 reset clears fault
    rst_ni = 1'b0;
    idle(2);
    chk(fault_o == 1'b0 && state_o == 2'd0, "R1 reset clears fault", fault_o, 0);
    chk(code_o == 8'd255, "R1 reset code again", code_o, 255);
    rst_ni = 1'b1;
    idle(2);
    summary();
  end
endmodule